// File: doc/BRIEF.md
# Windowed Integer Register File with Overlapping Frames

This block holds the integer registers of a processor that renames its registers on every procedure call. Software always sees 32 registers, numbered 0 to 31 by a 5-bit visible number. Numbers 0 to 7 name a set of shared registers that every procedure sees. Numbers 8 to 31 name the 24 registers of the current frame, which is picked by a window pointer. Inside a frame, numbers 8 to 15 are the outgoing group, 16 to 23 the private group, and 24 to 31 the incoming group. The frames sit on a ring of `NWIN` windows. A called procedure's incoming group is the same storage as its caller's outgoing group, so arguments and results pass between procedures without any copy.

A save command moves the pointer one window down the ring, modulo `NWIN`, when a procedure is entered. A restore command moves it one window up when the procedure returns. Each window has a bit in an invalid mask. A command that would enter a marked window does not move the pointer. It raises an overflow trap (save) or an underflow trap (restore) in the same cycle, so that a handler can spill or refill frames and then load a new mask. Spilling and filling themselves are outside this block.

Top module: `winreg_file`

## Requirements
- R1: A synchronous reset with `rst_n` low sets the window pointer to 0, loads the invalid mask with only bit 1 set (window 1), and clears every physical register to zero.
- R2: Visible registers 0 to 7 name the same storage whatever window is current.
- R3: After a save from window w to window w-1, visible registers 24+k (k = 0..7) read what registers 8+k held in window w. After a restore, the registers 8+k of the caller read what were the callee's registers 24+k.
- R4: Visible registers 16 to 23 are private to each window. A write to them in one window does not change what another window reads there.
- R5: A save whose target is not marked sets `cur_win` to (w-1) mod `NWIN`, so 0 goes to `NWIN`-1. A restore whose target is not marked sets it to (w+1) mod `NWIN`, so `NWIN`-1 goes to 0. The new value is visible from the clock edge that takes the command.
- R6: A save alone whose target window has its mask bit set drives `ovf_trap` high in the same cycle and leaves `cur_win` unchanged.
- R7: A restore alone whose target window has its mask bit set drives `unf_trap` high in the same cycle and leaves `cur_win` unchanged.
- R8: A read or a write in the same cycle as a save or restore uses the window pointer from before the change.
- R9: When `save_req` and `restore_req` are both high, the window pointer does not change and neither trap is raised.
- R10: With `mask_load` high, `mask_value` replaces the invalid mask at the clock edge. Trap decisions from the next cycle onward use the new mask (bit i marks window i).
- R11: Reads are combinational from the stored state, with no bypass. A read of the register being written in the same cycle returns the old value, and the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| save_req | input | 1 | Procedure-entry command: move to the next lower window |
| restore_req | input | 1 | Procedure-return command: move to the next higher window |
| mask_load | input | 1 | Load `mask_value` into the invalid mask |
| mask_value | input | NWIN | New invalid mask, bit i for window i |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Visible register number to write |
| wr_data | input | XLEN | Write data |
| rd_a_addr | input | 5 | Visible register number, read port A |
| rd_a_data | output | XLEN | Read data, port A |
| rd_b_addr | input | 5 | Visible register number, read port B |
| rd_b_data | output | XLEN | Read data, port B |
| cur_win | output | 5 | Current window pointer |
| ovf_trap | output | 1 | Save refused because the target window is marked |
| unf_trap | output | 1 | Restore refused because the target window is marked |

## Verification
The pointer properties assume that `save_req` and `restore_req` are held stable around each clock edge. They also assume that the reset is synchronous, so that one low-`rst_n` edge is enough to reach the reset state. The bench changes every input only on the falling edge and holds it through the next rising edge. It samples the combinational traps and read data a few nanoseconds after driving, and the registered pointer after the edge. It drives only the default ring of eight windows. It keeps every mask it loads non-empty but never full, so each wrap case it checks has a legal path.

// File: rtl/wrf_pkg.sv
// Package: shared constants and the visible-register classification used by
// the windowed register file. Assumes a 5-bit visible register number.
package wrf_pkg;

    localparam int VADDR_W     = 5;   // visible register number width
    localparam int CWP_W       = 5;   // exported window pointer width
    localparam int GLOBAL_REGS = 8;   // shared registers 0..7
    localparam int GROUP_REGS  = 8;   // registers per group inside a frame
    localparam int WIN_STRIDE  = 16;  // new physical registers per window

    // Group a visible register number falls into.
    typedef enum logic [1:0] {
        VG_SHARED  = 2'd0,
        VG_OUTGO   = 2'd1,
        VG_PRIVATE = 2'd2,
        VG_INCOME  = 2'd3
    } vgroup_e;

    // Classify a visible register number by its upper two bits.
    function automatic vgroup_e vgroup_of(input logic [VADDR_W-1:0] vnum);
        vgroup_e g;
        case (vnum[4:3])
            2'd0:    g = VG_SHARED;
            2'd1:    g = VG_OUTGO;
            2'd2:    g = VG_PRIVATE;
            default: g = VG_INCOME;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/wrf_xlate.sv
// Module: wrf_xlate
// Maps one visible register number to a physical storage index.
// Shared registers map straight to indices 0..7. Windowed registers map to
// 8 + ((win*16 + (vnum-8)) mod (16*NWIN)), so a window's incoming group lands
// on the outgoing group of the next higher window.
// Assumes win < NWIN, so a single conditional subtract finishes the modulo.
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int WIN_W  = 3,
    parameter int PIDX_W = 8
) (
    input  logic [VADDR_W-1:0] vnum,
    input  logic [WIN_W-1:0]   win,
    output logic [PIDX_W-1:0]  pidx
);
    localparam int SPAN   = WIN_STRIDE * NWIN;
    localparam int SPAN_W = $clog2(SPAN) + 1;

    logic [VADDR_W-1:0] frame_off;
    logic [SPAN_W-1:0]  raw_pos;
    logic [SPAN_W-1:0]  ring_pos;

    // Offset of the visible number inside the 24-register frame.
    assign frame_off = vnum - VADDR_W'(GLOBAL_REGS);

    // Position on the ring before and after the wrap.
    always_comb begin
        raw_pos  = ({{(SPAN_W-WIN_W){1'b0}}, win} << 4) + SPAN_W'(frame_off);
        ring_pos = (raw_pos >= SPAN_W'(SPAN)) ? raw_pos - SPAN_W'(SPAN) : raw_pos;
    end

    // Select the shared path or the windowed path.
    always_comb begin
        if (vgroup_of(vnum) == VG_SHARED) begin
            pidx = PIDX_W'(vnum);
        end else begin
            pidx = PIDX_W'(GLOBAL_REGS) + PIDX_W'(ring_pos);
        end
    end

endmodule

// File: rtl/wrf_winctl.sv
// Module: wrf_winctl
// Holds the window pointer and the invalid mask. Decides whether a save or a
// restore may move the pointer and raises the matching trap in the same
// cycle. A save and a restore in the same cycle cancel each other.
// Assumes NWIN >= 2.
module wrf_winctl #(
    parameter int NWIN  = 8,
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             mask_load,
    input  logic [NWIN-1:0]  mask_value,
    output logic [WIN_W-1:0] win,
    output logic [NWIN-1:0]  win_mask,
    output logic             ovf_trap,
    output logic             unf_trap
);
    localparam logic [WIN_W-1:0] LAST_WIN   = WIN_W'(NWIN - 1);
    localparam logic [NWIN-1:0]  RESET_MASK = NWIN'(2);

    logic [WIN_W-1:0] down_tgt;
    logic [WIN_W-1:0] up_tgt;
    logic             only_save;
    logic             only_rest;

    // Neighbours of the current window on the ring.
    always_comb begin
        down_tgt = (win == '0) ? LAST_WIN : win - WIN_W'(1);
        up_tgt   = (win == LAST_WIN) ? '0 : win + WIN_W'(1);
    end

    // Lone commands and their trap decisions against the current mask.
    always_comb begin
        only_save = save_req & ~restore_req;
        only_rest = restore_req & ~save_req;
        ovf_trap  = only_save & win_mask[down_tgt];
        unf_trap  = only_rest & win_mask[up_tgt];
    end

    // Pointer register: moves only on an untrapped lone command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (only_save && !ovf_trap) begin
            win <= down_tgt;
        end else if (only_rest && !unf_trap) begin
            win <= up_tgt;
        end
    end

    // Invalid-mask register: replaced whole on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_mask <= RESET_MASK;
        end else if (mask_load) begin
            win_mask <= mask_value;
        end
    end

endmodule

// File: rtl/wrf_store.sv
// Module: wrf_store
// Flat physical register storage with one write port and two combinational
// read ports addressed by physical index. Writes land at the clock edge.
// Reads show the stored value with no bypass.
// Assumes every index it receives is below NREGS.
module wrf_store #(
    parameter int NREGS  = 136,
    parameter int XLEN   = 32,
    parameter int PIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [PIDX_W-1:0] rd_idx_a,
    output logic [XLEN-1:0]   rd_data_a,
    input  logic [PIDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]   rd_data_b
);
    logic [XLEN-1:0] cells [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        // One physical register: cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (wr_en && wr_idx == PIDX_W'(g)) begin
                cells[g] <= wr_data;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_data_a = cells[rd_idx_a];
        rd_data_b = cells[rd_idx_b];
    end

endmodule

// File: rtl/winreg_file.sv
// Module: winreg_file (top)
// Windowed integer register file: 32 visible registers, 8 shared and 24
// taken from a ring of NWIN overlapping windows. Three translators map the
// two read numbers and the write number with the window pointer as it stood
// before any save or restore of this cycle. The window controller moves the
// pointer and raises the overflow and underflow traps.
// Assumes 2 <= NWIN <= 32 and synchronous reset.
module winreg_file
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               save_req,
    input  logic               restore_req,
    input  logic               mask_load,
    input  logic [NWIN-1:0]    mask_value,
    input  logic               wr_en,
    input  logic [VADDR_W-1:0] wr_addr,
    input  logic [XLEN-1:0]    wr_data,
    input  logic [VADDR_W-1:0] rd_a_addr,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [VADDR_W-1:0] rd_b_addr,
    output logic [XLEN-1:0]    rd_b_data,
    output logic [CWP_W-1:0]   cur_win,
    output logic               ovf_trap,
    output logic               unf_trap
);
    localparam int WIN_W  = (NWIN > 2) ? $clog2(NWIN) : 1;
    localparam int NREGS  = GLOBAL_REGS + WIN_STRIDE * NWIN;
    localparam int PIDX_W = $clog2(NREGS);
    localparam int NPORTS = 3;

    logic [WIN_W-1:0]   win;
    logic [NWIN-1:0]    win_mask;
    logic [VADDR_W-1:0] port_vnum [NPORTS];
    logic [PIDX_W-1:0]  port_pidx [NPORTS];

    // Window pointer, mask and trap decisions.
    wrf_winctl #(.NWIN(NWIN), .WIN_W(WIN_W)) u_winctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_load   (mask_load),
        .mask_value  (mask_value),
        .win         (win),
        .win_mask    (win_mask),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    // Gather the visible numbers: port 0 write, 1 read A, 2 read B.
    always_comb begin
        port_vnum[0] = wr_addr;
        port_vnum[1] = rd_a_addr;
        port_vnum[2] = rd_b_addr;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_xlate
        wrf_xlate #(.NWIN(NWIN), .WIN_W(WIN_W), .PIDX_W(PIDX_W)) u_xlate (
            .vnum (port_vnum[p]),
            .win  (win),
            .pidx (port_pidx[p])
        );
    end

    // Physical storage.
    wrf_store #(.NREGS(NREGS), .XLEN(XLEN), .PIDX_W(PIDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (port_pidx[0]),
        .wr_data   (wr_data),
        .rd_idx_a  (port_pidx[1]),
        .rd_data_a (rd_a_data),
        .rd_idx_b  (port_pidx[2]),
        .rd_data_b (rd_b_data)
    );

    // Export the pointer at the fixed 5-bit width.
    assign cur_win = CWP_W'(win);

endmodule

// File: rtl/winreg_file_chk.sv
// Module: winreg_file_chk
// Temporal checks on the window pointer and the traps of winreg_file,
// attached through bind. Assumes the commands are stable around each edge.
module winreg_file_chk #(
    parameter int NWIN = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       save_req,
    input logic       restore_req,
    input logic       ovf_trap,
    input logic       unf_trap,
    input logic [4:0] cur_win
);
    // R1
    reset_win_chk: assert property (@(posedge clk)
        !rst_n |=> cur_win == 5'd0);

    // R5
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && !restore_req && !ovf_trap |=>
            cur_win == (($past(cur_win) == 5'd0) ? 5'(NWIN - 1) : $past(cur_win) - 5'd1));

    // R5
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req && !save_req && !unf_trap |=>
            cur_win == (($past(cur_win) == 5'(NWIN - 1)) ? 5'd0 : $past(cur_win) + 5'd1));

    // R6
    no_overflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> $stable(cur_win));

    // R6
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> save_req && !restore_req);

    // R7
    no_underflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> $stable(cur_win));

    // R7
    underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> restore_req && !save_req);

    // R9
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && restore_req |=> $stable(cur_win));

    // R9
    both_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && restore_req |-> !ovf_trap && !unf_trap);

endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap),
    .cur_win     (cur_win)
);

// File: tb/test_winreg_file.sv
module test_winreg_file;
    localparam int NWIN = 8;
    localparam int XLEN = 32;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SV = 2'd2, OP_RS = 2'd3;
    localparam int NVEC = 18;
    // Vector fields: {req[3:0], op[1:0], addr[4:0], data[31:0], win[4:0], trap[1:0]}
    // trap field: bit 1 = ovf_trap, bit 0 = unf_trap
    localparam logic [49:0] VECS [NVEC] = '{
        {4'd2,  OP_WR, 5'd3,  32'h33, 5'd0, 2'b00},  // R2 shared write
        {4'd3,  OP_WR, 5'd8,  32'hA0, 5'd0, 2'b00},  // R3 outgoing of window 0
        {4'd4,  OP_WR, 5'd16, 32'hB0, 5'd0, 2'b00},  // R4 private of window 0
        {4'd5,  OP_SV, 5'd0,  32'h0,  5'd7, 2'b00},  // R5 0 wraps to 7
        {4'd2,  OP_RD, 5'd3,  32'h33, 5'd0, 2'b00},  // R2 shared seen in window 7
        {4'd3,  OP_RD, 5'd24, 32'hA0, 5'd0, 2'b00},  // R3 incoming = caller outgoing
        {4'd4,  OP_RD, 5'd16, 32'h0,  5'd0, 2'b00},  // R4 private not shared
        {4'd4,  OP_WR, 5'd16, 32'hC7, 5'd0, 2'b00},
        {4'd3,  OP_WR, 5'd8,  32'hD7, 5'd0, 2'b00},
        {4'd5,  OP_SV, 5'd0,  32'h0,  5'd6, 2'b00},
        {4'd3,  OP_RD, 5'd24, 32'hD7, 5'd0, 2'b00},
        {4'd5,  OP_RS, 5'd0,  32'h0,  5'd7, 2'b00},
        {4'd4,  OP_RD, 5'd16, 32'hC7, 5'd0, 2'b00},
        {4'd5,  OP_RS, 5'd0,  32'h0,  5'd0, 2'b00},  // R5 7 wraps to 0
        {4'd4,  OP_RD, 5'd16, 32'hB0, 5'd0, 2'b00},
        {4'd3,  OP_RD, 5'd8,  32'hA0, 5'd0, 2'b00},
        {4'd7,  OP_RS, 5'd0,  32'h0,  5'd0, 2'b01},  // R7 window 1 marked
        {4'd3,  OP_RD, 5'd8,  32'hA0, 5'd0, 2'b00}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            save_req = 1'b0, restore_req = 1'b0, mask_load = 1'b0;
    logic [NWIN-1:0] mask_value = '0;
    logic            wr_en = 1'b0;
    logic [4:0]      wr_addr = '0, rd_a_addr = '0, rd_b_addr = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data;
    logic [4:0]      cur_win;
    logic            ovf_trap, unf_trap;
    int checks = 0, bad = 0;
    bit done = 0;

    winreg_file #(.NWIN(NWIN), .XLEN(XLEN)) i_winreg_file (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .mask_load(mask_load), .mask_value(mask_value), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_a_addr(rd_a_addr),
        .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .cur_win(cur_win), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle();
        save_req = 0; restore_req = 0; mask_load = 0; wr_en = 0;
    endtask

    // Lone save or restore; checks traps in the cycle and the pointer after.
    task automatic step_win(input int rq, input bit is_save, input logic [4:0] exp_win,
                            input logic [1:0] exp_trap);
        save_req = is_save; restore_req = !is_save;
        #2 chk(rq, {30'd0, ovf_trap, unf_trap}, {30'd0, exp_trap});
        @(negedge clk); idle();
        #1 chk(rq, {27'd0, cur_win}, {27'd0, exp_win});
    endtask

    task automatic rd_both(input int rq, input logic [4:0] a, input logic [31:0] exp);
        rd_a_addr = a; rd_b_addr = a;
        #2 chk(rq, rd_a_data, exp); chk(rq, rd_b_data, exp);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); idle();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(1, {27'd0, cur_win}, 32'd0);
        for (int i = 0; i < 32; i++) rd_both(1, 5'(i), 32'd0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [49:0] e;
            e = VECS[v];
            case (e[45:44])
                OP_WR: wr(e[43:39], e[38:7]);
                OP_RD: rd_both(int'(e[49:46]), e[43:39], e[38:7]);
                OP_SV: step_win(int'(e[49:46]), 1'b1, e[6:2], e[1:0]);
                default: step_win(int'(e[49:46]), 1'b0, e[6:2], e[1:0]);
            endcase
        end

        // R5/R6: walk down to window 2, then the save into window 1 traps
        for (int k = 0; k < 6; k++) step_win(5, 1'b1, 5'(7 - k), 2'b00);
        step_win(6, 1'b1, 5'd2, 2'b10);
        // R5: walk back up, 7 wraps to 0
        for (int k = 0; k < 6; k++) step_win(5, 1'b0, 5'((3 + k) % 8), 2'b00);

        // R8: write and read in the save cycle use the old window
        save_req = 1; wr_en = 1; wr_addr = 5'd8; wr_data = 32'h55; rd_a_addr = 5'd16;
        #2 chk(8, rd_a_data, 32'hB0);
        @(negedge clk); idle();
        #1 chk(8, {27'd0, cur_win}, 32'd7);
        rd_both(8, 5'd24, 32'h55);
        restore_req = 1; wr_en = 1; wr_addr = 5'd24; wr_data = 32'h66; rd_b_addr = 5'd24;
        #2 chk(8, rd_b_data, 32'h55);
        @(negedge clk); idle();
        #1 chk(8, {27'd0, cur_win}, 32'd0);
        rd_both(3, 5'd8, 32'h66);

        // R9: both commands together do nothing
        save_req = 1; restore_req = 1;
        #2 chk(9, {30'd0, ovf_trap, unf_trap}, 32'd0);
        @(negedge clk); idle();
        #1 chk(9, {27'd0, cur_win}, 32'd0);

        // R11: no bypass on a same-cycle read of the written register
        wr_en = 1; wr_addr = 5'd5; wr_data = 32'h77; rd_a_addr = 5'd5;
        #2 chk(11, rd_a_data, 32'd0);
        @(negedge clk); idle();
        rd_both(11, 5'd5, 32'h77);

        // R10: new mask marks window 7 only
        mask_load = 1; mask_value = 8'h80;
        @(negedge clk); idle();
        step_win(10, 1'b1, 5'd0, 2'b10);
        step_win(10, 1'b0, 5'd1, 2'b00);

        // R1: a second reset restores the pointer, mask and contents
        do_reset();
        #1 chk(1, {27'd0, cur_win}, 32'd0);
        rd_both(1, 5'd8, 32'd0);
        rd_both(1, 5'd3, 32'd0);
        step_win(1, 1'b0, 5'd0, 2'b01);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule